// File: doc/BRIEF.md
# Dual-Bank Edge Interrupt Controller

This block gathers 64 interrupt sources into a single interrupt line and a single wake request. The sources are split into two banks of 32. Each source passes through a two-flop synchroniser. An edge detector then compares the current synchronised level against the previous one, after both have been XORed with the source's polarity bit. A detected edge latches a pending bit. Software reads the pending bits over a small memory-mapped register port and clears them by writing ones.

The combined output is the registered OR of pending-and-enabled bits across both banks. It is meant for an upstream rising-edge detector. Any write to a pending register forces the output low for one cycle. If enabled sources are still pending, the output then rises again and the upstream detector sees a fresh event.

Because the polarity bit sits in the edge comparison, toggling it and restoring it on a level-held input produces one detected edge. Software uses this to re-trigger a source. Each source also has a separate wake polarity and wake enable. Together they drive a latched wake request that does not depend on the interrupt enables.

Top module: `irqc_dualbank`

## Requirements
- R1: After reset, every register (enable, edge polarity, pending, wake enable, wake polarity) in both banks reads 0, and `irq_out` and `wake_req` are 0.
- R2: `bus_addr[3]` selects the bank: 0 is sources 0..31 and 1 is sources 32..63. `bus_addr[2:0]` selects the register: 0 enable, 1 edge polarity, 2 pending, 3 wake enable, 4 wake polarity. Codes 5..7 read 0, and writes to them change nothing. `bus_rdata` reflects `bus_addr` in the same cycle.
- R3: An edge polarity bit of 0 makes a rising input edge set the pending bit, and a bit of 1 makes a falling edge set it. The opposite edge leaves the pending bit unchanged. The bit is visible within 4 clock cycles of the input change.
- R4: A pending bit is set on its edge even when its enable bit is 0. Such a bit does not raise `irq_out`.
- R5: Writing to the pending register clears exactly the bits written as 1. A written 0 leaves its bit unchanged, and an all-ones write clears the whole bank.
- R6: `irq_out` is 1 one cycle after some source in either bank has both its pending and enable bits set. It is 0 one cycle after no such source exists.
- R7: In the cycle after any write to a pending register, `irq_out` is 0. In the following cycle it returns to 1 if enabled pending sources remain.
- R8: On a held input level, switching the polarity bit to the value that sees the level as already past its edge sets nothing. Switching it back sets the pending bit, which gives a software re-trigger.
- R9: A wake-enabled source whose input makes an edge in its wake polarity (0 rising, 1 falling) raises `wake_req`, whatever the interrupt enable and edge polarity. `wake_req` holds until that source's pending bit is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Bank bit and register code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_in | input | 64 | Interrupt sources, bit n is source n |
| irq_out | output | 1 | Combined interrupt |
| wake_req | output | 1 | Latched wake request |

## Verification
Sources in each bank are driven both rising and falling under both polarities, so an inverted polarity decode or a swapped bank shows up as a wrong pending word. The partial clear and the all-ones clear are tried while the other bank still holds an enabled pending bit. This separates a correct one-cycle low pulse on `irq_out` from a missing pulse or a stuck-low output. A held-high source is re-triggered through the polarity toggle, and the bench confirms that only the restoring write sets the bit. The wake path is tried with interrupt enable off and in both wake polarities, which shows that the wake request follows its own polarity and is released only by the pending clear.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int REG_SEL_W = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        RG_ENABLE   = 3'd0,
        RG_EDGE_POL = 3'd1,
        RG_PENDING  = 3'd2,
        RG_WAKE_EN  = 3'd3,
        RG_WAKE_POL = 3'd4
    } irqc_reg_e;

    typedef struct packed {
        logic                 wr;
        logic [REG_SEL_W-1:0] sel;
    } irqc_access_t;

    function automatic logic is_pending_write(irqc_access_t a);
        return a.wr && (a.sel == RG_PENDING);
    endfunction

    function automatic logic is_reg_write(irqc_access_t a, irqc_reg_e r);
        return a.wr && (a.sel == r);
    endfunction
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
`timescale 1ns/1ps
module irqc_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] int_pol,
    input  logic [W-1:0] wake_pol,
    output logic [W-1:0] int_edge,
    output logic [W-1:0] wake_edge
);
    // Level seen through each polarity; a 0->1 change is the edge.
    logic [W-1:0] int_view, wake_view;
    logic [W-1:0] int_prev_q, wake_prev_q;

    assign int_view  = level ^ int_pol;
    assign wake_view = level ^ wake_pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_prev_q  <= '0;
            wake_prev_q <= '0;
        end else begin
            int_prev_q  <= int_view;
            wake_prev_q <= wake_view;
        end
    end

    assign int_edge  = int_view  & ~int_prev_q;
    assign wake_edge = wake_view & ~wake_prev_q;
endmodule

// File: rtl/irqc_bank.sv
`timescale 1ns/1ps
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  irqc_access_t acc,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] int_edge,
    input  logic [W-1:0] wake_edge,
    output logic [W-1:0] int_pol,
    output logic [W-1:0] wake_pol,
    output logic [W-1:0] rdata,
    output logic         pend_hit,
    output logic         wake_hit,
    output logic         wen_hit,
    output logic         clr_hit
);
    logic [W-1:0] en_q, pol_q, pend_q, wen_q, wpol_q, wlat_q;
    logic [W-1:0] clr_mask;

    assign clr_hit  = is_pending_write(acc);
    assign clr_mask = clr_hit ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            pend_q <= '0;
            wen_q  <= '0;
            wpol_q <= '0;
            wlat_q <= '0;
        end else begin
            if (is_reg_write(acc, RG_ENABLE))   en_q   <= wdata;
            if (is_reg_write(acc, RG_EDGE_POL)) pol_q  <= wdata;
            if (is_reg_write(acc, RG_WAKE_EN))  wen_q  <= wdata;
            if (is_reg_write(acc, RG_WAKE_POL)) wpol_q <= wdata;
            // A new edge in the clearing cycle wins over the clear.
            pend_q <= (pend_q & ~clr_mask) | int_edge;
            wlat_q <= (wlat_q & ~clr_mask) | (wake_edge & wen_q);
        end
    end

    always_comb begin
        case (acc.sel)
            RG_ENABLE:   rdata = en_q;
            RG_EDGE_POL: rdata = pol_q;
            RG_PENDING:  rdata = pend_q;
            RG_WAKE_EN:  rdata = wen_q;
            RG_WAKE_POL: rdata = wpol_q;
            default:     rdata = '0;
        endcase
    end

    assign int_pol  = pol_q;
    assign wake_pol = wpol_q;
    assign pend_hit = |(pend_q & en_q);
    assign wake_hit = |wlat_q;
    assign wen_hit  = |wen_q;
endmodule

// File: rtl/irqc_dualbank.sv
`timescale 1ns/1ps
module irqc_dualbank
    import irqc_pkg::*;
#(
    parameter  int BANK_W    = 32,
    parameter  int NUM_BANKS = 2,
    parameter  int SYNC_LEN  = 2,
    localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = REG_SEL_W + BANK_SEL_W,
    localparam int SRC_W      = BANK_W * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [SRC_W-1:0]  src_in,
    output logic              irq_out,
    output logic              wake_req
);
    logic [SRC_W-1:0]     src_sync;
    logic [BANK_W-1:0]    bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] pend_vec, wake_vec, wen_vec, clr_vec;
    logic [BANK_SEL_W-1:0] bank_idx;
    logic pend_any, wen_any, stat_wr_any;
    logic irq_q;

    assign bank_idx = bus_addr[ADDR_W-1:REG_SEL_W];

    irqc_sync #(.W(SRC_W), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (src_in),
        .sync_out (src_sync)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            irqc_access_t acc;
            logic [BANK_W-1:0] ipol, wpol, iedge, wedge;

            assign acc.wr  = bus_wr && (bank_idx == BANK_SEL_W'(b));
            assign acc.sel = bus_addr[REG_SEL_W-1:0];

            irqc_edge #(.W(BANK_W)) u_edge (
                .clk       (clk),
                .rst       (rst),
                .level     (src_sync[b*BANK_W +: BANK_W]),
                .int_pol   (ipol),
                .wake_pol  (wpol),
                .int_edge  (iedge),
                .wake_edge (wedge)
            );

            irqc_bank #(.W(BANK_W)) u_bank (
                .clk       (clk),
                .rst       (rst),
                .acc       (acc),
                .wdata     (bus_wdata),
                .int_edge  (iedge),
                .wake_edge (wedge),
                .int_pol   (ipol),
                .wake_pol  (wpol),
                .rdata     (bank_rd[b]),
                .pend_hit  (pend_vec[b]),
                .wake_hit  (wake_vec[b]),
                .wen_hit   (wen_vec[b]),
                .clr_hit   (clr_vec[b])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_SEL_W'(b)) bus_rdata = bank_rd[b];
        end
    end

    assign pend_any    = |pend_vec;
    assign wen_any     = |wen_vec;
    assign stat_wr_any = |clr_vec;

    // A pending-register write forces one low cycle so the line re-pulses.
    always_ff @(posedge clk) begin
        if (rst)              irq_q <= 1'b0;
        else if (stat_wr_any) irq_q <= 1'b0;
        else                  irq_q <= pend_any;
    end

    assign irq_out  = irq_q;
    assign wake_req = |wake_vec;
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk (
    input logic clk,
    input logic rst,
    input logic stat_wr_any,
    input logic pend_any,
    input logic wen_any,
    input logic irq_out,
    input logic wake_req
);
    // R7
    clear_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr_any |=> !irq_out);

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_any && !stat_wr_any) |=> irq_out);

    // R6
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_any |=> !irq_out);

    // R9
    wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wen_any && !wake_req) |=> !wake_req);
endmodule

bind irqc_dualbank irqc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .stat_wr_any (stat_wr_any),
    .pend_any    (pend_any),
    .wen_any     (wen_any),
    .irq_out     (irq_out),
    .wake_req    (wake_req)
);

// File: tb/irqc_dualbank_test.sv
`timescale 1ns/1ps
module irqc_dualbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_out, wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;  // 0 irq_out, 1 wake_req, 2 bus_rdata
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    irqc_dualbank uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_out   (irq_out),
        .wake_req  (wake_req)
    );

    always #2.5 clk = ~clk;

    // Monitor: pops expectations and compares away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = {31'd0, irq_out};
                1:       act = {31'd0, wake_req};
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step(1);
        bus_wr    = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = 2; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        step(1);
    endtask

    task automatic exp_pin(input int kind, input logic v, input string tag);
        item_t it;
        it.kind = kind; it.exp = {31'd0, v}; it.tag = tag;
        sb_q.push_back(it);
        step(1);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        for (int r = 0; r < 5; r++) begin
            exp_rd(4'(r), 32'h0, "R1 low bank reg");
            exp_rd(4'(8 + r), 32'h0, "R1 high bank reg");
        end
        exp_pin(0, 1'b0, "R1 irq_out");
        exp_pin(1, 1'b0, "R1 wake_req");

        // R3 R4: rising edge latches while disabled, no interrupt
        src_in[3] = 1'b1;
        step(6);
        exp_rd(4'd2, 32'h0000_0008, "R3 rising edge pending");
        exp_pin(0, 1'b0, "R4 disabled source silent");
        wr(4'd0, 32'h0000_0008);
        step(2);
        exp_pin(0, 1'b1, "R6 enabled pending raises irq");

        // R3 falling polarity in high bank (pol write itself makes an edge)
        wr(4'd9, 32'h0000_0020);
        step(4);
        wr(4'd10, 32'hFFFF_FFFF);
        exp_rd(4'd10, 32'h0, "R5 all-ones clear high bank");
        src_in[37] = 1'b1;
        step(6);
        exp_rd(4'd10, 32'h0, "R3 rising ignored under falling polarity");
        src_in[37] = 1'b0;
        step(6);
        exp_rd(4'd10, 32'h0000_0020, "R3 falling edge pending");
        wr(4'd8, 32'h0000_0020);
        step(2);

        // R7 partial clear re-pulses the line
        wr(4'd2, 32'h0000_0008);
        exp_pin(0, 1'b0, "R7 forced low after clear");
        exp_pin(0, 1'b1, "R7 reasserts with pending left");
        exp_rd(4'd2, 32'h0, "R5 written one clears bit");
        wr(4'd10, 32'h0);
        exp_rd(4'd10, 32'h0000_0020, "R5 written zero keeps bit");
        wr(4'd10, 32'hFFFF_FFFF);
        exp_pin(0, 1'b0, "R7 low after final clear");
        exp_pin(0, 1'b0, "R6 stays low with nothing pending");

        // R2 reserved codes and bank decode
        wr(4'd5, 32'hFFFF_FFFF);
        exp_rd(4'd5, 32'h0, "R2 reserved reads zero");
        exp_rd(4'd0, 32'h0000_0008, "R2 low enable unchanged");
        exp_rd(4'd8, 32'h0000_0020, "R2 high enable");
        exp_rd(4'd9, 32'h0000_0020, "R2 high polarity");
        exp_rd(4'd1, 32'h0, "R2 low polarity");

        // R8 re-trigger on a held-high input
        src_in[10] = 1'b1;
        step(6);
        exp_rd(4'd2, 32'h0000_0400, "R3 second source pending");
        wr(4'd2, 32'h0000_0400);
        wr(4'd1, 32'h0000_0400);
        step(3);
        exp_rd(4'd2, 32'h0, "R8 first toggle sets nothing");
        wr(4'd1, 32'h0);
        step(3);
        exp_rd(4'd2, 32'h0000_0400, "R8 restore re-triggers");
        wr(4'd2, 32'h0000_0400);

        // R9 wake path, rising then falling wake polarity
        wr(4'd3, 32'h0000_1000);
        exp_rd(4'd3, 32'h0000_1000, "R2 wake enable reg");
        src_in[12] = 1'b1;
        step(6);
        exp_pin(1, 1'b1, "R9 wake on rising");
        exp_pin(0, 1'b0, "R9 wake independent of enable");
        wr(4'd2, 32'h0000_1000);
        exp_pin(1, 1'b0, "R9 wake released by clear");
        wr(4'd4, 32'h0000_1000);
        step(3);
        exp_pin(1, 1'b0, "R9 wake polarity change alone");
        src_in[12] = 1'b0;
        step(6);
        exp_pin(1, 1'b1, "R9 wake on falling");
        exp_rd(4'd2, 32'h0, "R9 falling not an interrupt edge");
        wr(4'd2, 32'h0000_1000);
        exp_pin(1, 1'b0, "R9 wake released again");

        step(2);
        done = 1'b1;
        report();
    end
endmodule